// File: doc/BRIEF.md
# Addressable Bit Latch with Clear

This block is a bank of individually addressable storage bits. An address selects one bit position, and a single data input is steered into that position. An active-low write enable and an active-low clear together choose one of four modes:

- **Write:** the addressed bit takes the data input and every other bit keeps its value.
- **Hold:** all bits keep their values.
- **Clear all:** every bit goes low.
- **Decoder (demultiplexer):** the addressed bit follows the data input and every other bit is driven low.

The level-sensitive behaviour is modelled with a fast sampling clock. On every rising edge, each bit updates from the inputs present at that edge. The outputs therefore follow the inputs one clock later. While writing stays active, the addressed bit tracks the data input on every edge. When writing stops, the bit keeps the last value it sampled. The block uses a synchronous, active-high reset. The address width is a parameter, and the number of bits is two to the power of that width.

Top module: `addr_latch`

## Requirements
- R1: While `rst` is high at a rising edge of `clk`, all bits of `q` are 0 after that edge.
- R2: With `clr_n`=1 and `wr_en_n`=0 at an edge, after that edge `q[addr]` equals the `din` value sampled at the edge, and every other bit of `q` keeps its value.
- R3: With `clr_n`=1 and `wr_en_n`=1 at an edge, `q` is unchanged after that edge, whatever `addr` and `din` are.
- R4: With `clr_n`=0 and `wr_en_n`=1 at an edge, all bits of `q` are 0 after that edge, whatever `addr` and `din` are.
- R5: With `clr_n`=0 and `wr_en_n`=0 at an edge, after that edge `q[addr]` equals the sampled `din` and every other bit of `q` is 0.
- R6: `addr` is an unsigned binary index, with `addr[0]` as the least significant bit. Value k selects `q[k]`, so 0 selects `q[0]` and 7 selects `q[7]`.
- R7: If `addr` changes while the block stays in write mode, the newly addressed bit takes `din`. Bits addressed earlier keep the last value they sampled.
- R8: A change of mode takes effect at the first edge at which the new mode is sampled. This holds for every pair of modes, including a clear during a write and a return from decoder mode to hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | ADDR_W | Bit select index |
| din | input | 1 | Data value steered to the selected bit |
| wr_en_n | input | 1 | Active-low write enable |
| clr_n | input | 1 | Active-low clear |
| q | output | 2**ADDR_W | Stored bits |

## Verification
The bench builds the block with the default `ADDR_W` of 3, which gives eight outputs. At this size every address can be swept exhaustively in each of the write and decoder modes, and every one of the sixteen ordered mode pairs can be reached directly. A long pseudo-random phase mixes address changes inside write bursts with clears and decoder episodes. A behavioural model of the eight bits is compared with `q` after every clock.

// File: rtl/addr_latch_pkg.sv
package addr_latch_pkg;

    typedef enum logic [1:0] {
        MODE_HOLD  = 2'd0,
        MODE_WRITE = 2'd1,
        MODE_CLEAR = 2'd2,
        MODE_DEMUX = 2'd3
    } latch_mode_e;

    typedef struct packed {
        latch_mode_e mode;
        logic        din;
    } cell_ctrl_t;

    function automatic latch_mode_e decode_mode(input logic clr_n, input logic wr_en_n);
        latch_mode_e m;
        case ({clr_n, wr_en_n})
            2'b11:   m = MODE_HOLD;
            2'b10:   m = MODE_WRITE;
            2'b01:   m = MODE_CLEAR;
            default: m = MODE_DEMUX;
        endcase
        return m;
    endfunction

    function automatic logic cell_next(input cell_ctrl_t c, input logic sel, input logic cur);
        logic n;
        case (c.mode)
            MODE_HOLD:  n = cur;
            MODE_WRITE: n = sel ? c.din : cur;
            MODE_CLEAR: n = 1'b0;
            default:    n = sel ? c.din : 1'b0;
        endcase
        return n;
    endfunction

endpackage

// File: rtl/addr_latch_mode_dec.sv
module addr_latch_mode_dec
    import addr_latch_pkg::*;
(
    input  logic       clr_n,
    input  logic       wr_en_n,
    input  logic       din,
    output cell_ctrl_t ctrl
);
    always_comb begin
        ctrl.mode = decode_mode(clr_n, wr_en_n);
        ctrl.din  = din;
    end
endmodule

// File: rtl/addr_latch_sel_dec.sv
module addr_latch_sel_dec #(
    parameter int ADDR_W = 3,
    localparam int NBITS = 1 << ADDR_W
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [NBITS-1:0]  sel
);
    for (genvar i = 0; i < NBITS; i++) begin : g_sel
        assign sel[i] = (addr == ADDR_W'(i));
    end
endmodule

// File: rtl/addr_latch_cell.sv
module addr_latch_cell
    import addr_latch_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  cell_ctrl_t ctrl,
    input  logic       sel,
    output logic       q
);
    always_ff @(posedge clk) begin
        if (rst) q <= 1'b0;
        else     q <= cell_next(ctrl, sel, q);
    end
endmodule

// File: rtl/addr_latch.sv
module addr_latch
    import addr_latch_pkg::*;
#(
    parameter int ADDR_W = 3,
    localparam int NBITS = 1 << ADDR_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic              din,
    input  logic              wr_en_n,
    input  logic              clr_n,
    output logic [NBITS-1:0]  q
);
    cell_ctrl_t       ctrl;
    logic [NBITS-1:0] sel;

    addr_latch_mode_dec u_mode (
        .clr_n   (clr_n),
        .wr_en_n (wr_en_n),
        .din     (din),
        .ctrl    (ctrl)
    );

    addr_latch_sel_dec #(.ADDR_W(ADDR_W)) u_sel (
        .addr (addr),
        .sel  (sel)
    );

    for (genvar i = 0; i < NBITS; i++) begin : g_cell
        addr_latch_cell u_cell (
            .clk  (clk),
            .rst  (rst),
            .ctrl (ctrl),
            .sel  (sel[i]),
            .q    (q[i])
        );
    end
endmodule

// File: rtl/addr_latch_chk.sv
module addr_latch_chk #(
    parameter int ADDR_W = 3,
    localparam int NBITS = 1 << ADDR_W
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] addr,
    input logic              din,
    input logic              wr_en_n,
    input logic              clr_n,
    input logic [NBITS-1:0]  q
);
    // R1
    reset_zero_chk: assert property (@(posedge clk) $past(rst) |-> q == '0);

    // R2 R6 R7
    write_bit_chk: assert property (@(posedge clk) disable iff (rst)
        (clr_n && !wr_en_n) |=> q[$past(addr)] == $past(din));

    // R2 R7
    write_others_chk: assert property (@(posedge clk) disable iff (rst)
        (clr_n && !wr_en_n) |=>
            (((q ^ $past(q)) & ~(NBITS'(1) << $past(addr))) == '0));

    // R3
    hold_stable_chk: assert property (@(posedge clk) disable iff (rst)
        (clr_n && wr_en_n) |=> $stable(q));

    // R4
    clear_all_chk: assert property (@(posedge clk) disable iff (rst)
        (!clr_n && wr_en_n) |=> q == '0);

    // R5
    demux_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        (!clr_n && !wr_en_n) |=> $onehot0(q) && q[$past(addr)] == $past(din));
endmodule

bind addr_latch addr_latch_chk #(.ADDR_W(ADDR_W)) u_addr_latch_chk (
    .clk     (clk),
    .rst     (rst),
    .addr    (addr),
    .din     (din),
    .wr_en_n (wr_en_n),
    .clr_n   (clr_n),
    .q       (q)
);

// File: tb/test_addr_latch.sv
`timescale 1ns/1ps
module test_addr_latch;
    localparam int ADDR_W = 3;
    localparam int NBITS  = 1 << ADDR_W;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [ADDR_W-1:0] addr = '0;
    logic              din = 1'b0;
    logic              wr_en_n = 1'b1;
    logic              clr_n = 1'b1;
    logic [NBITS-1:0]  q;

    int model [NBITS];
    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;

    always #4 clk = ~clk;

    addr_latch #(.ADDR_W(ADDR_W)) i_addr_latch (
        .clk(clk), .rst(rst), .addr(addr), .din(din),
        .wr_en_n(wr_en_n), .clr_n(clr_n), .q(q)
    );

    function automatic logic [NBITS-1:0] model_vec();
        logic [NBITS-1:0] v;
        for (int i = 0; i < NBITS; i++) v[i] = (model[i] != 0);
        return v;
    endfunction

    // Called at a negedge: drive inputs, let one rising edge pass,
    // update the model, then compare at the following negedge.
    task automatic cyc(input int a, input int d, input int en_n, input int cl_n,
                       input string tag);
        addr    = ADDR_W'(a);
        din     = d[0];
        wr_en_n = en_n[0];
        clr_n   = cl_n[0];
        @(posedge clk);
        for (int i = 0; i < NBITS; i++) begin
            if (rst) model[i] = 0;
            else if (cl_n != 0 && en_n == 0) begin
                if (i == a) model[i] = d;
            end else if (cl_n == 0 && en_n != 0) model[i] = 0;
            else if (cl_n == 0 && en_n == 0) model[i] = (i == a) ? d : 0;
        end
        @(negedge clk);
        n_cmp++;
        if (q !== model_vec()) begin
            n_bad++;
            $display("FAIL %s: q=%b expected %b", tag, q, model_vec());
        end
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: finished=0 expected 1");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin : stim
        int seed;
        seed = 7;
        for (int i = 0; i < NBITS; i++) model[i] = 0;
        @(negedge clk);
        // R1: reset clears everything
        cyc(0, 1, 0, 1, "R1 reset");
        cyc(5, 1, 0, 0, "R1 reset");
        rst = 1'b0;
        // R2 R6: walk addresses writing ones
        for (int a = 0; a < NBITS; a++) cyc(a, 1, 0, 1, "R2 R6 write one");
        // R3: hold ignores addr/din
        for (int a = 0; a < NBITS; a++) cyc(a, 0, 1, 1, "R3 hold");
        // R2: write zeros to odd positions
        for (int a = 1; a < NBITS; a += 2) cyc(a, 0, 0, 1, "R2 write zero");
        cyc(2, 0, 1, 1, "R3 hold after write");
        // R8: clear during write
        cyc(4, 1, 0, 1, "R8 write before clear");
        cyc(4, 1, 1, 0, "R4 R8 clear during write");
        cyc(6, 1, 1, 0, "R4 clear ignores inputs");
        // R7: address changes inside one write burst
        cyc(1, 1, 0, 1, "R7 burst");
        cyc(3, 1, 0, 1, "R7 burst");
        cyc(6, 0, 0, 1, "R7 burst");
        cyc(7, 1, 0, 1, "R7 burst");
        cyc(0, 0, 1, 1, "R7 burst end hold");
        // R5 R6: decoder sweep
        for (int a = 0; a < NBITS; a++) begin
            cyc(a, 1, 0, 0, "R5 R6 demux one");
            cyc(a, 0, 0, 0, "R5 demux zero");
        end
        cyc(2, 1, 0, 0, "R5 demux");
        // R8: decoder back to hold
        cyc(5, 0, 1, 1, "R8 demux to hold");
        cyc(5, 0, 1, 1, "R3 hold");
        // R8: all ordered mode pairs
        for (int m1 = 0; m1 < 4; m1++)
            for (int m2 = 0; m2 < 4; m2++) begin
                cyc(m1 + m2, 1, m1 & 1, m1 >> 1, "R8 pair first");
                cyc(7 - m2, 1, m2 & 1, m2 >> 1, "R8 pair second");
            end
        // mixed pseudo-random phase
        for (int k = 0; k < 400; k++) begin
            int r;
            r = $urandom(seed + k);
            cyc(r & 7, (r >> 3) & 1, ((r >> 4) & 3) != 0 ? 0 : 1,
                ((r >> 6) & 7) != 0 ? 1 : 0, "R2 R3 R4 R5 random");
        end
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule